// File: doc/BRIEF.md
# Capture/Reload Timer-Counter with Baud Mode

A 16-bit timer/counter controlled by an 8-bit control register. The counter advances either once every twelve system clocks or on each falling edge of an external count pin. A second external pin, the trigger, can do one of two things on a falling edge: copy the counter into a shared capture/reload register, or load the counter from that register. It does neither unless the external enable bit is set. On overflow the counter either wraps to zero or loads itself from the capture/reload register, depending on the mode.

Setting either of the two baud select bits makes the block act as a baud clock source for a serial port. In this mode the prescaler divides by two, overflow always reloads, the overflow flag stays clear, trigger edges leave the counter and the capture register alone, and each overflow gives a one-cycle pulse on `baud_tick`. Software reaches the control, counter and capture/reload registers through a simple write/read port. `irq` is high whenever either status flag is set.

Top module: `cr_timer`

## Requirements
- R1: After reset the control, counter and capture/reload registers read 0, and both `irq` and `baud_tick` are low.
- R2: While control bit 2 (run) is 0 and bit 3 (external enable) is 0, the counter holds its value.
- R3: With run=1, bit 1 (source) = 0 and both baud bits 0, the counter advances by one on every 12th clock edge after the write that sets run.
- R4: With run=1 and source=1, each falling edge on `cnt_pin` advances the counter by exactly one, and rising edges have no effect.
- R5: With control bit 0 (capture select) = 1 and no baud bit set, overflow from 0xFFFF wraps the counter to 0 and sets control bit 7 (overflow flag), which drives `irq` high.
- R6: With capture select = 0, overflow loads the counter from the capture/reload register and sets the overflow flag.
- R7: With external enable = 1, capture select = 1 and no baud bit set, a falling edge on `trig_pin` copies the counter into the capture/reload register, leaves the counter alone and sets control bit 6 (external flag).
- R8: With external enable = 1, capture select = 0 and no baud bit set, a falling edge on `trig_pin` loads the counter from the capture/reload register and sets the external flag.
- R9: With external enable = 0, falling edges on `trig_pin` do not set the external flag and do not change the capture/reload register.
- R10: With bit 5 (receive baud) or bit 4 (transmit baud) set and source = 0, the counter advances every 2 clocks and overflow always reloads, whatever capture select holds. The overflow flag is never set, and `baud_tick` is high for exactly one cycle per overflow.
- R11: With a baud bit set and external enable = 1, trigger edges still set the external flag but neither load the counter nor change the capture/reload register.
- R12: The overflow and external flags stay set until software writes 0 to them through the control register, and `irq` follows their OR.
- R13: A software write to the counter takes effect even in a cycle where the counter would have advanced.

Register addresses on `bus_addr`: 0 = control (low 8 bits), 1 = counter, 2 = capture/reload, 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr` (combinational) |
| cnt_pin | input | 1 | External count pin, counted on falling edges |
| trig_pin | input | 1 | External trigger pin, acts on falling edges |
| irq | output | 1 | Interrupt request, OR of the two flags |
| baud_tick | output | 1 | One-cycle pulse for each overflow in baud mode |

## Verification
The properties assume that the two pins idle high and that each level lasts several clocks, so that the two-flop synchroniser sees every edge. They also assume that software changes the flags only through whole writes to the control register. The bench holds each pin level for at least four cycles, keeps the pins high while it reconfigures the block, and writes the control register only between scenarios or at points where a flag change is expected. Checks of counter values are timed from the clock edge that sets run, counting the prescaler and the three pin flops, so each expected value lands on a known cycle.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
  // control register bit positions
  localparam int CB_OVF  = 7;
  localparam int CB_EXT  = 6;
  localparam int CB_RXB  = 5;
  localparam int CB_TXB  = 4;
  localparam int CB_EXEN = 3;
  localparam int CB_RUN  = 2;
  localparam int CB_SRC  = 1;
  localparam int CB_CAP  = 0;
  localparam int CTRL_W  = 8;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_COUNT  = 2'd1,
    RA_CAPREL = 2'd2,
    RA_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cr_timer_fall.sv
module cr_timer_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  // STAGES synchroniser flops followed by one history flop
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/cr_timer_presc.sv
module cr_timer_presc #(
  parameter int TIMER_DIV = 12,
  parameter int BAUD_DIV  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic tick
);
  localparam int MAXDIV = (TIMER_DIV > BAUD_DIV) ? TIMER_DIV : BAUD_DIV;
  localparam int W      = $clog2(MAXDIV + 1);
  localparam logic [W-1:0] LIM_T = W'(TIMER_DIV - 1);
  localparam logic [W-1:0] LIM_B = W'(BAUD_DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] limit;

  always_comb begin
    limit = fast ? LIM_B : LIM_T;
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (cnt_q >= limit) begin
      cnt_d = '0;
      tick  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cr_timer_core.sv
module cr_timer_core
  import cr_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_count,
  input  logic              wr_caprel,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              inc,
  input  logic              trig_fall,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  caprel_q,
  output logic              baud_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [CNT_W-1:0]  count_d, caprel_d;
  logic              baud_d;
  logic              baud_mode, ext_evt, trig_cap, trig_rel, ovf, auto_rel;

  always_comb begin
    baud_mode = ctrl_q[CB_RXB] | ctrl_q[CB_TXB];
    ext_evt   = trig_fall & ctrl_q[CB_EXEN];
    trig_cap  = ext_evt & ~baud_mode &  ctrl_q[CB_CAP];
    trig_rel  = ext_evt & ~baud_mode & ~ctrl_q[CB_CAP];
    ovf       = inc & (&count_q);
    auto_rel  = baud_mode | ~ctrl_q[CB_CAP];

    // counter: software write, then trigger reload, then overflow, then step
    count_d = count_q;
    if (wr_count)      count_d = wdata;
    else if (trig_rel) count_d = caprel_q;
    else if (ovf)      count_d = auto_rel ? caprel_q : '0;
    else if (inc)      count_d = count_q + 1'b1;

    caprel_d = caprel_q;
    if (wr_caprel)     caprel_d = wdata;
    else if (trig_cap) caprel_d = count_q;

    ctrl_d = wr_ctrl ? wdata[CTRL_W-1:0] : ctrl_q;
    if (ovf && !baud_mode) ctrl_d[CB_OVF] = 1'b1;
    if (ext_evt)           ctrl_d[CB_EXT] = 1'b1;

    baud_d = ovf & baud_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      count_q  <= '0;
      caprel_q <= '0;
      baud_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      count_q  <= count_d;
      caprel_q <= caprel_d;
      baud_q   <= baud_d;
    end
  end
endmodule

// File: rtl/cr_timer.sv
module cr_timer
  import cr_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TIMER_DIV   = 12,
  parameter int BAUD_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cnt_pin,
  input  logic             trig_pin,
  output logic             irq,
  output logic             baud_tick
);
  localparam int NPINS = 2;

  logic [NPINS-1:0]  pin_vec, fall_vec;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  count_q, caprel_q;
  logic              pre_tick, pre_en, baud_mode, inc;
  logic              wr_ctrl, wr_count, wr_caprel;
  reg_addr_e         addr_e;

  assign pin_vec = {trig_pin, cnt_pin};

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    cr_timer_fall #(.STAGES(SYNC_STAGES)) u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_vec[gi]),
      .fall (fall_vec[gi])
    );
  end

  always_comb begin
    addr_e    = reg_addr_e'(bus_addr);
    baud_mode = ctrl_q[CB_RXB] | ctrl_q[CB_TXB];
    pre_en    = ctrl_q[CB_RUN] & ~ctrl_q[CB_SRC];
    inc       = ctrl_q[CB_RUN] & (ctrl_q[CB_SRC] ? fall_vec[0] : pre_tick);
    wr_ctrl   = bus_we && (addr_e == RA_CTRL);
    wr_count  = bus_we && (addr_e == RA_COUNT);
    wr_caprel = bus_we && (addr_e == RA_CAPREL);
  end

  cr_timer_presc #(.TIMER_DIV(TIMER_DIV), .BAUD_DIV(BAUD_DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pre_en),
    .fast (baud_mode),
    .tick (pre_tick)
  );

  cr_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_count (wr_count),
    .wr_caprel(wr_caprel),
    .wdata    (bus_wdata),
    .inc      (inc),
    .trig_fall(fall_vec[1]),
    .ctrl_q   (ctrl_q),
    .count_q  (count_q),
    .caprel_q (caprel_q),
    .baud_q   (baud_tick)
  );

  always_comb begin
    case (addr_e)
      RA_CTRL:   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      RA_COUNT:  bus_rdata = count_q;
      RA_CAPREL: bus_rdata = caprel_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = ctrl_q[CB_OVF] | ctrl_q[CB_EXT];
endmodule

// File: rtl/cr_timer_chk.sv
module cr_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [7:0]       ctrl_q,
  input logic [CNT_W-1:0] count_q,
  input logic             baud_tick
);
  // R2
  hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !ctrl_q[3] && !(bus_we && bus_addr == 2'd1)) |=> $stable(count_q));

  // R9
  ext_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[6]) |-> ($past(ctrl_q[3]) || $past(bus_we && bus_addr == 2'd0)));

  // R10
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[7]) |-> (!$past(ctrl_q[5] | ctrl_q[4]) || $past(bus_we && bus_addr == 2'd0)));

  // R10
  baud_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && !(bus_we && bus_addr == 2'd0)) |=> ctrl_q[7]);

  // R13
  count_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1) |=> (count_q == $past(bus_wdata)));
endmodule

bind cr_timer cr_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .ctrl_q   (ctrl_q),
  .count_q  (count_q),
  .baud_tick(baud_tick)
);

// File: tb/cr_timer_tb.sv
module cr_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        cnt_pin = 1'b1;
  logic        trig_pin = 1'b1;
  logic        irq, baud_tick;
  int          checks = 0;
  int          fails = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  cr_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .irq(irq), .baud_tick(baud_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic trig_pulse();
    trig_pin = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic trig_release();
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 count", v, 0);
    rd(2'd2, v); chk("R1 caprel", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 baud_tick", baud_tick, 0);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'h0000);
    repeat (30) @(negedge clk);
    rd(2'd1, v); chk("R2 hold", v, 16'h1234);
  endtask

  task automatic t_timer();
    logic [15:0] v;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0004);
    repeat (11) @(negedge clk);
    rd(2'd1, v); chk("R3 before 12th edge", v, 0);
    @(negedge clk);
    rd(2'd1, v); chk("R3 at 12th edge", v, 1);
    repeat (113) @(negedge clk);
    rd(2'd1, v); chk("R3 after 125 edges", v, 10);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_counter();
    logic [15:0] v;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0006);
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1'b0; repeat (4) @(negedge clk);
      cnt_pin = 1'b1; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd(2'd1, v); chk("R4 five falling edges", v, 5);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_ovf_wrap();
    logic [15:0] v;
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'h5555);
    wr(2'd0, 16'h0005);
    repeat (30) @(negedge clk);
    rd(2'd1, v); chk("R5 wrap to zero", v, 0);
    rd(2'd0, v); chk("R5 overflow flag", v[7], 1);
    chk("R5 irq", irq, 1);
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R12 flag sticky", v[7], 1);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R12 flag cleared", v, 0);
    chk("R12 irq low", irq, 0);
  endtask

  task automatic t_ovf_reload();
    logic [15:0] v;
    wr(2'd2, 16'h1234);
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h0004);
    repeat (14) @(negedge clk);
    rd(2'd1, v); chk("R6 reload on overflow", v, 16'h1234);
    rd(2'd0, v); chk("R6 overflow flag", v[7], 1);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wr(2'd1, 16'h00AB);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0009);
    trig_pulse();
    rd(2'd2, v); chk("R7 captured", v, 16'h00AB);
    rd(2'd1, v); chk("R7 count kept", v, 16'h00AB);
    rd(2'd0, v); chk("R7 ext flag", v[6], 1);
    chk("R12 irq from ext flag", irq, 1);
    trig_release();
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_trig_reload();
    logic [15:0] v;
    wr(2'd2, 16'h4321);
    wr(2'd1, 16'h0007);
    wr(2'd0, 16'h0008);
    trig_pulse();
    rd(2'd1, v); chk("R8 trigger reload", v, 16'h4321);
    rd(2'd0, v); chk("R8 ext flag", v[6], 1);
    trig_release();
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    wr(2'd1, 16'h0099);
    wr(2'd2, 16'h0011);
    wr(2'd0, 16'h0001);
    trig_pulse();
    rd(2'd2, v); chk("R9 no capture", v, 16'h0011);
    rd(2'd0, v); chk("R9 no ext flag", v[6], 0);
    chk("R9 irq low", irq, 0);
    trig_release();
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_baud();
    logic [15:0] v;
    int pulses = 0;
    logic prev = 1'b0;
    logic twice = 1'b0;
    wr(2'd2, 16'hFFF0);
    wr(2'd1, 16'hFFF0);
    wr(2'd0, 16'h0015);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (baud_tick) pulses++;
      if (baud_tick && prev) twice = 1'b1;
      prev = baud_tick;
    end
    chk("R10 baud pulses", pulses, 2);
    chk("R10 pulse one cycle", twice, 0);
    rd(2'd1, v); chk("R10 reload despite capture select", v, 16'hFFF3);
    rd(2'd0, v); chk("R10 no overflow flag", v[7], 0);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_baud_trig();
    logic [15:0] v;
    wr(2'd1, 16'h0050);
    wr(2'd2, 16'h0777);
    wr(2'd0, 16'h0028);
    trig_pulse();
    rd(2'd1, v); chk("R11 no reload", v, 16'h0050);
    rd(2'd2, v); chk("R11 caprel kept", v, 16'h0777);
    rd(2'd0, v); chk("R11 ext flag", v[6], 1);
    trig_release();
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_wr_prio();
    logic [15:0] v;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0004);
    repeat (11) @(negedge clk);
    wr(2'd1, 16'h2000);
    rd(2'd1, v); chk("R13 write beats step", v, 16'h2000);
    wr(2'd0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_timer();
    t_counter();
    t_ovf_wrap();
    t_ovf_reload();
    t_capture();
    t_trig_reload();
    t_ignore();
    t_baud();
    t_baud_trig();
    t_wr_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule